// File: doc/BRIEF.md
# Multi-Width Unsigned Sequential Divider

This block divides an unsigned dividend of twice the operand width by an unsigned divisor of one operand width, for operand widths of 8, 16 or 32 bits chosen per operation. It returns a truncated quotient and a remainder, each one operand wide, packed into a single result word. The quotient is in the lower half and the remainder in the upper half, which matches the way a register pair holds the dividend.

An operation is launched with a one-cycle `start` while the block is idle. A fault check runs at once on the captured operands. If the divisor is zero, or the quotient cannot fit in one operand width, the block reports a divide error on the next cycle and leaves the result untouched. Otherwise a restoring shift-subtract loop produces one quotient bit per clock, and `done` pulses when the last bit is in. The error flag stays valid from `done` until the next accepted start.

Top module: `udiv_multisize`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done` and `div_err` are 0 and `result` is all zeros.
- R2: `size` sets the operand width W: 0 gives W=8, 1 gives W=16, and 2 or 3 give W=32. Only `dividend[2W-1:0]` and `divisor[W-1:0]` are used, and higher input bits have no effect.
- R3: On success, `result[W-1:0]` holds floor(dividend/divisor), `result[2W-1:W]` holds the remainder, and every result bit above 2W-1 is 0.
- R4: On success, the remainder field is strictly less than the divisor.
- R5: A divisor of zero, within the width used, raises `div_err` together with `done`, and `result` keeps its previous value.
- R6: If the true quotient exceeds 2^W-1, the block raises `div_err` together with `done`, and `result` keeps its previous value.
- R7: Count the rising edge that samples `start` as edge 1. A faulting operation shows `done` after edge 1. A successful one shows `done` after edge W+1.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start until the cycle in which a successful `done` appears, and never together with `done`.
- R9: `start` is ignored while `busy` is high. The running operation's result and latency are unchanged.
- R10: `div_err` is cleared by the next accepted start, and until then it holds its value after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation when idle |
| size | input | 2 | Operand width select (0: 8, 1: 16, 2/3: 32) |
| dividend | input | 64 | Double-width dividend, upper half in the high bits |
| divisor | input | 32 | Divisor, low W bits used |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error: zero divisor or quotient overflow |
| result | output | 64 | Remainder in bits 2W-1:W, quotient in bits W-1:0 |

## Verification
A faulting operation completes after the edge that samples `start`. A successful one completes after W more edges, so the bench expects `done` 1, 9, 17 or 33 edges after the start edge. The bench drives its inputs on falling edges and polls `done` on each falling edge, counting edges from the one that samples `start`. It compares that count with the expected latency, then reads `result` and `div_err` on that same falling edge, and checks on the following one that `done` has dropped. The hold of `div_err` is checked several cycles after a fault, and its clearing on the falling edge after the next start.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  // operand width select encoding
  typedef enum logic [1:0] {
    SZ_NARROW = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_FULL   = 2'd2,
    SZ_FULL_B = 2'd3
  } size_e;

  // quarter / half / full of the widest operand
  function automatic int unsigned width_of(input logic [1:0] s, input int unsigned opw);
    case (s)
      2'd0:    return opw / 4;
      2'd1:    return opw / 2;
      default: return opw;
    endcase
  endfunction
endpackage

// File: rtl/udiv_guard.sv
// Operand alignment and fault detection at the selected width.
module udiv_guard #(
  parameter int unsigned OPW = 32,
  localparam int unsigned CW = $clog2(OPW),
  localparam int unsigned W0 = OPW / 4,
  localparam int unsigned W1 = OPW / 2
) (
  input  logic [1:0]       size,
  input  logic [2*OPW-1:0] dividend,
  input  logic [OPW-1:0]   divisor,
  output logic [OPW-1:0]   hi_ext,
  output logic [OPW-1:0]   lo_just,
  output logic [OPW-1:0]   dvs_ext,
  output logic [CW-1:0]    last_step,
  output logic             fault
);
  always_comb begin
    case (size)
      2'd0: begin
        hi_ext    = OPW'(dividend[2*W0-1:W0]);
        lo_just   = {dividend[W0-1:0], {(OPW-W0){1'b0}}};
        dvs_ext   = OPW'(divisor[W0-1:0]);
        last_step = CW'(W0 - 1);
      end
      2'd1: begin
        hi_ext    = OPW'(dividend[2*W1-1:W1]);
        lo_just   = {dividend[W1-1:0], {(OPW-W1){1'b0}}};
        dvs_ext   = OPW'(divisor[W1-1:0]);
        last_step = CW'(W1 - 1);
      end
      default: begin
        hi_ext    = dividend[2*OPW-1:OPW];
        lo_just   = dividend[OPW-1:0];
        dvs_ext   = divisor;
        last_step = CW'(OPW - 1);
      end
    endcase
    // upper half >= divisor means quotient overflow; covers a zero divisor too
    fault = (hi_ext >= dvs_ext);
  end
endmodule

// File: rtl/udiv_step.sv
// One restoring shift-subtract iteration.
module udiv_step #(
  parameter int unsigned OPW = 32
) (
  input  logic [OPW-1:0] rem_i,
  input  logic [OPW-1:0] quo_i,
  input  logic [OPW-1:0] dvs_i,
  output logic [OPW-1:0] rem_o,
  output logic [OPW-1:0] quo_o
);
  logic [OPW:0] trial;
  logic [OPW:0] diff;
  logic         qbit;

  always_comb begin
    trial = {rem_i, quo_i[OPW-1]};
    diff  = trial - {1'b0, dvs_i};
    qbit  = ~diff[OPW];
    rem_o = qbit ? diff[OPW-1:0] : trial[OPW-1:0];
    quo_o = {quo_i[OPW-2:0], qbit};
  end
endmodule

// File: rtl/udiv_pack.sv
// Places quotient and remainder at the selected width, zero above.
module udiv_pack #(
  parameter int unsigned OPW = 32,
  localparam int unsigned W0 = OPW / 4,
  localparam int unsigned W1 = OPW / 2
) (
  input  logic [1:0]       size,
  input  logic [OPW-1:0]   rem,
  input  logic [OPW-1:0]   quo,
  output logic [2*OPW-1:0] packed_o
);
  always_comb begin
    packed_o = '0;
    case (size)
      2'd0: begin
        packed_o[W0-1:0]    = quo[W0-1:0];
        packed_o[2*W0-1:W0] = rem[W0-1:0];
      end
      2'd1: begin
        packed_o[W1-1:0]    = quo[W1-1:0];
        packed_o[2*W1-1:W1] = rem[W1-1:0];
      end
      default: packed_o = {rem, quo};
    endcase
  end
endmodule

// File: rtl/udiv_multisize.sv
module udiv_multisize #(
  parameter int unsigned OPW = 32,
  localparam int unsigned CW = $clog2(OPW),
  localparam int unsigned RW = 2 * OPW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    size,
  input  logic [RW-1:0] dividend,
  input  logic [OPW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic          div_err,
  output logic [RW-1:0] result
);
  logic [OPW-1:0] g_hi, g_lo, g_dvs;
  logic [CW-1:0]  g_last;
  logic           g_fault;

  logic [OPW-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]  cnt_q;
  logic [1:0]     sz_q;
  logic [OPW-1:0] s_rem, s_quo;
  logic [RW-1:0]  pk;

  udiv_guard #(.OPW(OPW)) i_guard (
    .size(size), .dividend(dividend), .divisor(divisor),
    .hi_ext(g_hi), .lo_just(g_lo), .dvs_ext(g_dvs),
    .last_step(g_last), .fault(g_fault)
  );

  udiv_step #(.OPW(OPW)) i_step (
    .rem_i(rem_q), .quo_i(quo_q), .dvs_i(dvs_q),
    .rem_o(s_rem), .quo_o(s_quo)
  );

  udiv_pack #(.OPW(OPW)) i_pack (
    .size(sz_q), .rem(s_rem), .quo(s_quo), .packed_o(pk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      div_err <= 1'b0;
      result  <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      sz_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (g_fault) begin
            div_err <= 1'b1;
            done    <= 1'b1;
          end else begin
            div_err <= 1'b0;
            busy    <= 1'b1;
            rem_q   <= g_hi;
            quo_q   <= g_lo;
            dvs_q   <= g_dvs;
            cnt_q   <= g_last;
            sz_q    <= size;
          end
        end
      end else begin
        rem_q <= s_rem;
        quo_q <= s_quo;
        if (cnt_q == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= pk;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/udiv_multisize_chk.sv
module udiv_multisize_chk #(
  parameter int unsigned RW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          div_err,
  input logic [RW-1:0] result
);
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8: busy and done never overlap
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst) busy |-> !done);
  // R3: result changes only in a completion cycle
  p_result_quiet_r3: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(result));
  // R5 / R6: a fault leaves the result untouched
  p_err_keeps_result_r5: assert property (@(posedge clk) disable iff (rst) (done && div_err) |-> $stable(result));
  // R10: error appears only with done
  p_err_rise_r10: assert property (@(posedge clk) disable iff (rst) $rose(div_err) |-> done);
  // R10: error held until a start arrives
  p_err_hold_r10: assert property (@(posedge clk) disable iff (rst) (div_err && !start) |=> div_err);
  // R9: a start during an operation does not abort it
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> (busy || (done && !div_err)));
  // R6: never busy while an error is reported
  p_err_idle_r6: assert property (@(posedge clk) disable iff (rst) div_err |-> !busy);
endmodule

bind udiv_multisize udiv_multisize_chk #(.RW(2 * OPW)) i_chk (.*);

// File: tb/test_udiv_multisize.sv
module test_udiv_multisize;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  size = '0;
  logic [63:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, div_err;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [63:0] last_good = '0;

  always #2.5 clk = ~clk;

  udiv_multisize i_udiv_multisize (
    .clk(clk), .rst(rst), .start(start), .size(size),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_err(div_err), .result(result)
  );

  // {size, dividend, divisor}
  localparam int NV = 13;
  localparam logic [97:0] VEC [NV] = '{
    {2'd0, 64'h0000_0000_0000_1234, 32'h0000_0056},
    {2'd0, 64'h0000_0000_0000_00FF, 32'h0000_0001},
    {2'd0, 64'h0000_0000_0000_0100, 32'h0000_0001},   // overflow R6
    {2'd0, 64'h0000_0000_0000_0050, 32'hFFFF_FF00},   // zero at width R5, R2
    {2'd1, 64'h0000_0000_0012_3456, 32'h0000_1234},
    {2'd1, 64'h0000_0000_FFFE_FFFF, 32'h0000_FFFF},
    {2'd1, 64'hDEAD_BEEF_0001_0000, 32'hABCD_0003},   // upper bits ignored R2
    {2'd2, 64'h0000_0001_0000_0000, 32'h0000_0010},
    {2'd2, 64'hFFFF_FFFE_FFFF_FFFF, 32'hFFFF_FFFF},
    {2'd2, 64'h0000_0005_0000_0000, 32'h0000_0005},   // overflow R6
    {2'd3, 64'h0000_0000_DEAD_BEEF, 32'h0000_1234},   // size 3 is full width R2
    {2'd2, 64'h0000_0000_0000_0000, 32'h0000_0007},
    {2'd2, 64'h0000_0000_075B_CD15, 32'h0000_0000}    // zero divisor R5
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] s, input logic [63:0] a,
                                input logic [31:0] b, output bit err,
                                output logic [63:0] res, output int w);
    logic [63:0] m1, m2, dv, ds;
    w  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m1 = (64'd1 << w) - 64'd1;
    m2 = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
    dv = a & m2;
    ds = {32'b0, b} & m1;
    err = (ds == 0);
    res = '0;
    if (!err) begin
      err = (dv / ds) > m1;
      if (!err) res = ((dv % ds) << w) | (dv / ds);
    end
  endfunction

  task automatic run_op(input logic [1:0] s, input logic [63:0] a,
                        input logic [31:0] b, input bit interfere);
    bit err_e;
    logic [63:0] res_e, m1;
    int w, n, lat_e;
    logic b1;
    model(s, a, b, err_e, res_e, w);
    lat_e = err_e ? 1 : w + 1;
    m1 = (64'd1 << w) - 64'd1;
    @(negedge clk);
    size = s; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    b1 = busy;
    while (!done && n < 60) begin
      if (interfere && n == 3) begin
        start = 1'b1; size = 2'd0; dividend = 64'h0100; divisor = 32'h0;
      end
      if (interfere && n == 4) start = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n == lat_e, "R7", "done latency", 64'(n), 64'(lat_e));
    if (interfere) chk(n == lat_e && !div_err, "R9", "start while busy ignored", 64'(div_err), 64'(0));
    chk(div_err == err_e, err_e ? "R5/R6" : "R6", "div_err", 64'(div_err), 64'(err_e));
    if (err_e) begin
      chk(result == last_good, "R5", "result kept on fault", result, last_good);
    end else begin
      chk(b1 == 1'b1, "R8", "busy after start", 64'(b1), 64'(1));
      chk(result == res_e, "R3", "result (R2 width select)", result, res_e);
      chk(((result >> w) & m1) < (64'(b) & m1), "R4", "remainder below divisor",
          (result >> w) & m1, 64'(b) & m1);
      last_good = res_e;
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", 64'(done), 64'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog expired: actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(busy == 0 && done == 0 && div_err == 0, "R1", "flags in reset",
        {61'b0, busy, done, div_err}, 64'd0);
    chk(result == 64'd0, "R1", "result in reset", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && div_err == 0 && result == 0, "R1", "after reset",
        {61'b0, busy, done, div_err}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][97:96], VEC[i][95:32], VEC[i][31:0], 1'b0);
    end

    // R9: start pulse in mid-operation
    run_op(2'd1, 64'h0000_0000_0777_1234, 32'h0000_0FED, 1'b1);

    // R10: error held, then cleared by the next accepted start
    run_op(2'd0, 64'h0000_0000_0000_2000, 32'h0000_0010, 1'b0);
    repeat (5) @(negedge clk);
    chk(div_err == 1'b1, "R10", "error held while idle", 64'(div_err), 64'(1));
    size = 2'd0; dividend = 64'h0000_0000_0000_0064; divisor = 32'h0000_000A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(div_err == 1'b0, "R10", "error cleared by start", 64'(div_err), 64'(0));
    while (!done) @(negedge clk);
    chk(result == 64'h0000_0000_0000_000A, "R3", "result after clear", result, 64'h0A);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule